// File: doc/BRIEF.md
# Reloadable Sum-of-Products Logic Array

This block is a reloadable two-plane logic array. It has a parameterised number of logic inputs, product-term rows and outputs. Each row holds one product term. The row's AND part gives one two-bit literal code per input, and its OR part gives one connection bit per output. Rows are written one at a time through a synchronous configuration port.

Between writes, the outputs are a purely combinational sum of products of the live inputs. A single stored term may drive any number of outputs, so common terms are built only once.

An elaboration-time mode restricts the OR plane to fixed blocks of rows per output. In that mode each output sees only its own slice of the terms, as in a fixed-OR array. The AND plane stays fully programmable in both modes.

Top module: `pla_engine`

## Requirements
- R1: Input `i` of a row is coded in `cfgAnd[2i+1:2i]`. Code 2'b10 makes the term require `dataIn[i]`=1, code 2'b01 makes it require `dataIn[i]`=0, and code 2'b00 leaves the input out of the term. The term is the AND of all the literals that take part.
- R2: Code 2'b11 in any slot of a row forces that term to 0 for every input value.
- R3: A row whose slots are all 2'b00 evaluates to 1.
- R4: Bit `k` of a row's `cfgOr` connects the term to `dataOut[k]`, and `dataOut[k]` is the OR of its connected terms. An output with no connected term is 0.
- R5: One stored term connected to several outputs drives all of them at the same time.
- R6: With `PAL_MODE`=1, output `k` uses only rows `k*(P/NO)` through `(k+1)*(P/NO)-1`. Connection bits of other rows have no effect on output `k`. With `PAL_MODE`=0, any row may feed any output.
- R7: When `cfgWe` is high at a rising clock edge, row `cfgRow` is replaced from that edge on, and not before it. A write to a row index of `P` or above changes nothing.
- R8: A synchronous active-low reset sets every row to all-2'b11 slots with no connections, so all outputs read 0.
- R9: Inputs A, B, C are mapped to `dataIn[0..2]`. With the rows AB, B'C, AC', B'C' and A loaded and connected in PLA mode, the outputs are `dataOut[0]`=A+B'C', `dataOut[1]`=AC'+AB, `dataOut[2]`=B'C'+AB and `dataOut[3]`=B'C+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgWe | input | 1 | Row write enable |
| cfgRow | input | ROW_W | Index of the row to write |
| cfgAnd | input | 2*NI | Literal codes, two bits per input |
| cfgOr | input | NO | Output connection bits of the row |
| dataIn | input | NI | Logic inputs |
| dataOut | output | NO | Sum-of-products outputs |

## Verification
The reference personality is checked over all eight A/B/C combinations while the unused fourth input toggles. This separates literal polarity, an absent input, and a term that is shared between outputs.

A single negated literal on the top input separates the 2'b01 code from the 2'b10 code. A row with one 2'b11 slot and no other literal separates the forced-0 code from the all-absent constant-1 row.

The same write sequence drives a PLA-mode and a PAL-mode instance side by side. Any mismatch between the two exposes the row-slice masking. A sample taken before and after the capturing edge pins down write latency, and an out-of-range row index shows that such a write is dropped.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_ABSENT = 2'b00,
    LIT_NEG    = 2'b01,
    LIT_POS    = 2'b10,
    LIT_KILL   = 2'b11
  } litCode_e;

  typedef struct packed {
    logic rowLoad;
    logic rowClear;
  } cfgStrobe_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl import pla_pkg::*; #(
  parameter int P     = 12,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [ROW_W-1:0] cfgRow,
  output cfgStrobe_t       strobe,
  output logic [P-1:0]     rowSel
);
  localparam logic [ROW_W:0] ROWS = (ROW_W+1)'(P);

  logic inRange;
  assign inRange = ({1'b0, cfgRow} < ROWS);

  always_comb begin
    strobe.rowClear = !rstN;
    strobe.rowLoad  = rstN && cfgWe && inRange;
  end

  for (genvar t = 0; t < P; t++) begin : g_dec
    assign rowSel[t] = (cfgRow == ROW_W'(t));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel)) else $error("row select not onehot"); // R7
endmodule

// File: rtl/pla_array.sv
module pla_array import pla_pkg::*; #(
  parameter int NI       = 4,
  parameter int P        = 12,
  parameter int NO       = 4,
  parameter int PAL_MODE = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfgStrobe_t      strobe,
  input  logic [P-1:0]    rowSel,
  input  logic [2*NI-1:0] cfgAnd,
  input  logic [NO-1:0]   cfgOr,
  input  logic [NI-1:0]   dataIn,
  output logic [NO-1:0]   dataOut
);
  localparam int TPO = (P / NO > 0) ? P / NO : 1;

  logic [P-1:0][2*NI-1:0] andPlane;
  logic [P-1:0][NO-1:0]   orPlane;
  logic [P-1:0]           termVec;
  logic [NO-1:0][P-1:0]   colMask;

  always_ff @(posedge clk) begin
    for (int t = 0; t < P; t++) begin
      if (strobe.rowClear) begin
        andPlane[t] <= '1;
        orPlane[t]  <= '0;
      end else if (strobe.rowLoad && rowSel[t]) begin
        andPlane[t] <= cfgAnd;
        orPlane[t]  <= cfgOr;
      end
    end
  end

  function automatic logic termHit(input logic [2*NI-1:0] row, input logic [NI-1:0] in);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < NI; i++) begin
      case (litCode_e'(row[2*i +: 2]))
        LIT_POS:  hit = hit & in[i];
        LIT_NEG:  hit = hit & ~in[i];
        LIT_KILL: hit = 1'b0;
        default:  hit = hit;
      endcase
    end
    return hit;
  endfunction

  always_comb begin
    for (int t = 0; t < P; t++) termVec[t] = termHit(andPlane[t], dataIn);
  end

  for (genvar k = 0; k < NO; k++) begin : g_out
    for (genvar t = 0; t < P; t++) begin : g_term
      localparam logic OK = (PAL_MODE == 0) || ((t / TPO) == k);
      assign colMask[k][t] = orPlane[t][k] & OK;

      AST_ABSENT_ROW: assert property (@(posedge clk) disable iff (!rstN)
        (andPlane[t] == '0 && colMask[k][t]) |-> dataOut[k])
        else $error("all-absent row did not drive output"); // R3
    end
    assign dataOut[k] = |(termVec & colMask[k]);

    AST_EMPTY_OUT: assert property (@(posedge clk) disable iff (!rstN)
      (colMask[k] == '0) |-> !dataOut[k])
      else $error("unconnected output is high"); // R4
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rowLoad |=> ($stable(andPlane) && $stable(orPlane)))
    else $error("personality changed without a write"); // R7
endmodule

// File: rtl/pla_engine.sv
module pla_engine import pla_pkg::*; #(
  parameter int NI       = 4,
  parameter int P        = 12,
  parameter int NO       = 4,
  parameter int PAL_MODE = 0,
  localparam int ROW_W   = (P > 1) ? $clog2(P) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [ROW_W-1:0] cfgRow,
  input  logic [2*NI-1:0]  cfgAnd,
  input  logic [NO-1:0]    cfgOr,
  input  logic [NI-1:0]    dataIn,
  output logic [NO-1:0]    dataOut
);
  cfgStrobe_t   strobe;
  logic [P-1:0] rowSel;

  pla_ctrl #(.P(P), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRow(cfgRow),
    .strobe(strobe), .rowSel(rowSel)
  );

  pla_array #(.NI(NI), .P(P), .NO(NO), .PAL_MODE(PAL_MODE)) u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowSel(rowSel),
    .cfgAnd(cfgAnd), .cfgOr(cfgOr), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/sim_pla_engine.sv
module sim_pla_engine;
  logic clk = 0;
  logic rstN = 0;
  logic cfgWe = 0;
  logic [3:0] cfgRow = '0;
  logic [7:0] cfgAnd = '0;
  logic [3:0] cfgOr = '0;
  logic [3:0] dataIn = '0;
  logic [3:0] outPla, outPal;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  pla_engine #(.NI(4), .P(12), .NO(4), .PAL_MODE(0)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRow(cfgRow),
    .cfgAnd(cfgAnd), .cfgOr(cfgOr), .dataIn(dataIn), .dataOut(outPla));
  pla_engine #(.NI(4), .P(12), .NO(4), .PAL_MODE(1)) u1 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRow(cfgRow),
    .cfgAnd(cfgAnd), .cfgOr(cfgOr), .dataIn(dataIn), .dataOut(outPal));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; cfgWe = 0;
    @(negedge clk); rstN = 1;
  endtask

  task automatic writeRow(input int row, input logic [7:0] a, input logic [3:0] o);
    @(negedge clk);
    cfgWe = 1; cfgRow = 4'(row); cfgAnd = a; cfgOr = o;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic testReset();
    doReset();
    for (int v = 0; v < 16; v++) begin
      dataIn = 4'(v); #1;
      check("R8 reset PLA", outPla, 4'b0000);
      check("R8 reset PAL", outPal, 4'b0000);
    end
  endtask

  task automatic testExample();
    doReset();
    writeRow(0, 8'b00_00_10_10, 4'b0110); // AB
    writeRow(1, 8'b00_10_01_00, 4'b1000); // B'C
    writeRow(2, 8'b00_01_00_10, 4'b0010); // AC'
    writeRow(3, 8'b00_01_01_00, 4'b0101); // B'C'
    writeRow(4, 8'b00_00_00_10, 4'b1001); // A
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      logic [3:0] e;
      a = v[0]; b = v[1]; c = v[2];
      e[0] = a | (!b & !c);
      e[1] = (a & !c) | (a & b);
      e[2] = (!b & !c) | (a & b);
      e[3] = (!b & c) | a;
      dataIn = {a ^ b, c, b, a}; #1;
      check("R9 R1 R5 example PLA", outPla, e);
      check("R6 example PAL masked", outPal, 4'b0000);
    end
  endtask

  task automatic testNegated();
    doReset();
    writeRow(0, 8'b01_00_00_00, 4'b0001);
    for (int v = 0; v < 16; v++) begin
      dataIn = 4'(v); #1;
      check("R1 negated literal", outPla, {3'b000, ~dataIn[3]});
    end
  endtask

  task automatic testKillAndAbsent();
    doReset();
    writeRow(2, 8'b00_11_00_00, 4'b0001);
    for (int v = 0; v < 16; v++) begin
      dataIn = 4'(v); #1;
      check("R2 forced zero", outPla, 4'b0000);
    end
    writeRow(2, 8'b00_00_00_00, 4'b0010);
    for (int v = 0; v < 16; v += 5) begin
      dataIn = 4'(v); #1;
      check("R3 R4 absent row", outPla, 4'b0010);
    end
  endtask

  task automatic testTiming();
    doReset();
    dataIn = 4'b0101;
    @(negedge clk);
    cfgWe = 1; cfgRow = 4'd0; cfgAnd = 8'h00; cfgOr = 4'b0001;
    #1 check("R7 not before edge", outPla, 4'b0000);
    @(negedge clk);
    cfgWe = 0;
    #1 check("R7 after edge", outPla, 4'b0001);
    writeRow(12, 8'h00, 4'b1111);
    #1 check("R7 out-of-range row ignored", outPla, 4'b0001);
    writeRow(15, 8'h00, 4'b1110);
    #1 check("R7 top row index ignored", outPla, 4'b0001);
  endtask

  task automatic testPal();
    doReset();
    dataIn = 4'b0011;
    writeRow(4, 8'h00, 4'b1111);
    #1 check("R6 PLA any output", outPla, 4'b1111);
    check("R6 PAL slice 1 only", outPal, 4'b0010);
    writeRow(11, 8'h00, 4'b1000);
    #1 check("R6 PAL slice 3", outPal, 4'b1010);
    writeRow(11, 8'h00, 4'b0100);
    #1 check("R6 PAL foreign bit ignored", outPal, 4'b0010);
    check("R5 R6 PLA shared", outPla, 4'b1111);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testExample();
    testNegated();
    testKillAndAbsent();
    testTiming();
    testPal();
    finishRun();
  end
endmodule